// File: doc/BRIEF.md
# LPC Address Window Decoder

This block decides whether an incoming LPC cycle falls inside one of the address windows this slave answers to. It holds six windows. Each window has a 28-bit lower bound, a 28-bit upper bound, an on/off switch and two permission bits, one for I/O cycles and one for TPM cycles. A claim therefore depends on both the address and the kind of cycle. Firmware cycles and the reserved cycle kind are never claimed here; they always report a miss.

Software programs the windows through twelve 32-bit registers, two per window. The register with the even select value carries the switch, the permissions and the lower bound. The one with the odd select value carries the upper bound. The currently selected register can be read back at any time. A lookup is presented with `req_valid`. The verdict appears one clock later: a hit flag and the number of the window that claimed the cycle.

Top module: `lpc_window_decoder`

## Requirements
- R1: After reset, every configuration register reads as 0, `res_valid` is low and no lookup hits.
- R2: Select value 2*i addresses the head register of window i: bit 31 is the enable, bit 30 is the I/O permission, bit 29 is the TPM permission and bits 27:0 are the lower bound. Select value 2*i+1 addresses the tail register: bits 27:0 are the upper bound. Bit 28 of the head register and bits 31:28 of the tail register are not stored and read as 0.
- R3: A window whose enable bit is 0 never claims a cycle, whatever its bounds and permissions.
- R4: An I/O lookup (`req_kind` = 0) can be claimed only by a window with the I/O permission set. A TPM lookup (`req_kind` = 1) can be claimed only by a window with the TPM permission set.
- R5: A firmware lookup (`req_kind` = 2) and a reserved lookup (`req_kind` = 3) never hit.
- R6: A window claims an address only when lower bound <= address <= upper bound, with both bounds included. A window whose lower bound is above its upper bound claims nothing.
- R7: When several windows claim the same lookup, `hit_idx` reports the lowest-numbered one.
- R8: `res_valid` is high in exactly the cycle after a cycle with `req_valid` high. Lookups may arrive back to back. When `hit` is low, `hit_idx` is 0.
- R9: A register write and a lookup in the same cycle: the lookup is judged against the settings in force before that write.
- R10: Writes to select values 12 to 15 change nothing, and those select values read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 4 | Register select (even: head of window sel/2, odd: tail) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the selected register (combinational) |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 28 | Lookup address |
| req_kind | input | 2 | Cycle kind: 0 I/O, 1 TPM, 2 firmware, 3 reserved |
| res_valid | output | 1 | Verdict valid, one cycle after the request |
| hit | output | 1 | Lookup claimed by a window |
| hit_idx | output | 3 | Number of the claiming window, 0 on a miss |

## Verification
A register write and a lookup can land on the same clock edge. The bench provokes this by driving a lookup in the same cycle as a write that flips a window's enable, once to turn a window on and once to turn it off. Each such lookup must be judged on the old settings, and a second lookup right after it must reflect the new settings. The scoreboard computes both expected verdicts from its own shadow of the registers, which it updates only after it has queued the expectation for the simultaneous lookup.

// File: rtl/lpc_win_pkg.sv
package lpc_win_pkg;

  localparam int LPC_AW = 28;
  localparam int CFG_W  = 32;

  // head register bit positions
  localparam int EN_BIT  = 31;
  localparam int IO_BIT  = 30;
  localparam int TPM_BIT = 29;

  typedef enum logic [1:0] {
    KIND_IO   = 2'd0,
    KIND_TPM  = 2'd1,
    KIND_FW   = 2'd2,
    KIND_RSVD = 2'd3
  } lpc_kind_e;

  typedef struct packed {
    logic              en;
    logic              io_ok;
    logic              tpm_ok;
    logic [LPC_AW-1:0] lo;
    logic [LPC_AW-1:0] hi;
  } win_cfg_t;

  // cycle kind permitted by a window's permission bits
  function automatic logic kind_allowed(input win_cfg_t c, input logic [1:0] k);
    logic ok;
    case (k)
      KIND_IO:  ok = c.io_ok;
      KIND_TPM: ok = c.tpm_ok;
      default:  ok = 1'b0;
    endcase
    return ok;
  endfunction

  // inclusive bound test
  function automatic logic in_bounds(input logic [LPC_AW-1:0] lo,
                                     input logic [LPC_AW-1:0] hi,
                                     input logic [LPC_AW-1:0] a);
    return (a >= lo) && (a <= hi);
  endfunction

  function automatic logic [CFG_W-1:0] pack_head(input win_cfg_t c);
    logic [CFG_W-1:0] w;
    w = '0;
    w[EN_BIT]       = c.en;
    w[IO_BIT]       = c.io_ok;
    w[TPM_BIT]      = c.tpm_ok;
    w[LPC_AW-1:0]   = c.lo;
    return w;
  endfunction

  function automatic logic [CFG_W-1:0] pack_tail(input win_cfg_t c);
    logic [CFG_W-1:0] w;
    w = '0;
    w[LPC_AW-1:0] = c.hi;
    return w;
  endfunction

endpackage

// File: rtl/lpc_win_regs.sv
module lpc_win_regs
  import lpc_win_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_head,
  input  logic             wr_tail,
  input  logic [CFG_W-1:0] wdata,
  output win_cfg_t         cfg
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
    end else begin
      if (wr_head) begin
        cfg.en     <= wdata[EN_BIT];
        cfg.io_ok  <= wdata[IO_BIT];
        cfg.tpm_ok <= wdata[TPM_BIT];
        cfg.lo     <= wdata[LPC_AW-1:0];
      end
      if (wr_tail) begin
        cfg.hi <= wdata[LPC_AW-1:0];
      end
    end
  end

endmodule

// File: rtl/lpc_win_cmp.sv
module lpc_win_cmp
  import lpc_win_pkg::*;
(
  input  win_cfg_t          cfg,
  input  logic [LPC_AW-1:0] addr,
  input  logic [1:0]        kind,
  output logic              match
);

  logic kind_ok;
  logic addr_ok;

  assign kind_ok = kind_allowed(cfg, kind);
  assign addr_ok = in_bounds(cfg.lo, cfg.hi, addr);
  assign match   = cfg.en && kind_ok && addr_ok;

endmodule

// File: rtl/lpc_win_prio.sv
module lpc_win_prio #(
  parameter int N     = 6,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/lpc_window_decoder.sv
module lpc_window_decoder
  import lpc_win_pkg::*;
#(
  parameter int NUM_WIN = 6,
  localparam int SEL_W  = $clog2(2 * NUM_WIN),
  localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic              req_valid,
  input  logic [LPC_AW-1:0] req_addr,
  input  logic [1:0]        req_kind,
  output logic              res_valid,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx
);

  win_cfg_t           cfgs [NUM_WIN];
  logic [NUM_WIN-1:0] win_hit_vec;
  logic               any_hit;
  logic [IDX_W-1:0]   first_idx;

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    localparam logic [SEL_W-1:0] HEAD_SEL = SEL_W'(2 * g);
    localparam logic [SEL_W-1:0] TAIL_SEL = SEL_W'(2 * g + 1);

    logic wr_head;
    logic wr_tail;
    assign wr_head = cfg_we && (cfg_sel == HEAD_SEL);
    assign wr_tail = cfg_we && (cfg_sel == TAIL_SEL);

    lpc_win_regs u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_head (wr_head),
      .wr_tail (wr_tail),
      .wdata   (cfg_wdata),
      .cfg     (cfgs[g])
    );

    lpc_win_cmp u_cmp (
      .cfg   (cfgs[g]),
      .addr  (req_addr),
      .kind  (req_kind),
      .match (win_hit_vec[g])
    );
  end

  lpc_win_prio #(.N(NUM_WIN), .IDX_W(IDX_W)) u_prio (
    .vec (win_hit_vec),
    .any (any_hit),
    .idx (first_idx)
  );

  // read-back mux
  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (cfg_sel == SEL_W'(2 * i))     cfg_rdata = pack_head(cfgs[i]);
      if (cfg_sel == SEL_W'(2 * i + 1)) cfg_rdata = pack_tail(cfgs[i]);
    end
  end

  // verdict register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      hit       <= 1'b0;
      hit_idx   <= '0;
    end else begin
      res_valid <= req_valid;
      hit       <= req_valid && any_hit;
      hit_idx   <= (req_valid && any_hit) ? first_idx : '0;
    end
  end

endmodule

// File: rtl/lpc_win_chk.sv
module lpc_win_chk
  import lpc_win_pkg::*;
#(
  parameter int NUM_WIN = 6,
  localparam int SEL_W  = $clog2(2 * NUM_WIN),
  localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [1:0]         req_kind,
  input logic [SEL_W-1:0]   cfg_sel,
  input logic [CFG_W-1:0]   cfg_rdata,
  input logic               res_valid,
  input logic               hit,
  input logic [IDX_W-1:0]   hit_idx,
  input logic [NUM_WIN-1:0] win_hit_vec
);

  // R8
  req_to_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);

  // R8
  idle_no_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid && !hit);

  // R8
  miss_idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> hit_idx == '0);

  // R5
  fw_never_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind[1]) |=> res_valid && !hit);

  // R7
  match_gives_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && win_hit_vec != '0) |=> hit);

  // R7
  no_match_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && win_hit_vec == '0) |=> !hit);

  // R2
  head_rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cfg_sel) < 2 * NUM_WIN && !cfg_sel[0]) |-> cfg_rdata[LPC_AW] == 1'b0);

  // R2
  tail_rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cfg_sel) < 2 * NUM_WIN && cfg_sel[0]) |-> cfg_rdata[CFG_W-1:LPC_AW] == '0);

  // R10
  unused_sel_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cfg_sel) >= 2 * NUM_WIN) |-> cfg_rdata == '0);

  // R7
  idx_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> int'(hit_idx) < NUM_WIN);

endmodule

bind lpc_window_decoder lpc_win_chk #(.NUM_WIN(NUM_WIN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_kind    (req_kind),
  .cfg_sel     (cfg_sel),
  .cfg_rdata   (cfg_rdata),
  .res_valid   (res_valid),
  .hit         (hit),
  .hit_idx     (hit_idx),
  .win_hit_vec (win_hit_vec)
);

// File: tb/lpc_window_decoder_tb.sv
module lpc_window_decoder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NW = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic [27:0] req_addr = '0;
  logic [1:0]  req_kind = '0;
  logic        res_valid;
  logic        hit;
  logic [2:0]  hit_idx;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // shadow of the windows
  bit          m_en  [NW];
  bit          m_io  [NW];
  bit          m_tpm [NW];
  logic [27:0] m_lo  [NW];
  logic [27:0] m_hi  [NW];

  // scoreboard queues
  bit    exp_hit_q [$];
  int    exp_idx_q [$];
  string tag_q     [$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  lpc_window_decoder u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_kind  (req_kind),
    .res_valid (res_valid),
    .hit       (hit),
    .hit_idx   (hit_idx)
  );

  function automatic void predict(input logic [27:0] a, input logic [1:0] k,
                                  output bit h, output int idx);
    h = 1'b0;
    idx = 0;
    for (int w = 0; w < NW; w++) begin
      bit perm;
      perm = (k == 2'd0) ? m_io[w] : (k == 2'd1) ? m_tpm[w] : 1'b0;
      if (!h && m_en[w] && perm && a >= m_lo[w] && a <= m_hi[w]) begin
        h = 1'b1;
        idx = w;
      end
    end
  endfunction

  function automatic void shadow_write(input int sel, input logic [31:0] d);
    if (sel < 2 * NW) begin
      if (sel % 2 == 0) begin
        m_en[sel/2]  = d[31];
        m_io[sel/2]  = d[30];
        m_tpm[sel/2] = d[29];
        m_lo[sel/2]  = d[27:0];
      end else begin
        m_hi[sel/2]  = d[27:0];
      end
    end
  endfunction

  function automatic void check(input bit ok, input string tag,
                                input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endfunction

  // one-cycle operation: optional write and optional lookup together
  task automatic cycle_op(input bit do_wr, input int sel, input logic [31:0] d,
                          input bit do_rq, input logic [27:0] a,
                          input logic [1:0] k, input string tag);
    bit h;
    int idx;
    if (do_rq) begin
      predict(a, k, h, idx);
      exp_hit_q.push_back(h);
      exp_idx_q.push_back(idx);
      tag_q.push_back(tag);
    end
    cfg_we    = do_wr;
    cfg_sel   = 4'(sel);
    cfg_wdata = d;
    req_valid = do_rq;
    req_addr  = a;
    req_kind  = k;
    @(posedge clk);
    #1;
    if (do_wr) shadow_write(sel, d);
    cfg_we    = 1'b0;
    req_valid = 1'b0;
  endtask

  task automatic wr(input int sel, input logic [31:0] d);
    cycle_op(1'b1, sel, d, 1'b0, '0, 2'd0, "");
  endtask

  task automatic look(input logic [27:0] a, input logic [1:0] k, input string tag);
    cycle_op(1'b0, 0, '0, 1'b1, a, k, tag);
  endtask

  task automatic rd(input int sel, input logic [31:0] exp, input string tag);
    cfg_sel = 4'(sel);
    #1;
    check(cfg_rdata === exp, tag, cfg_rdata, exp);
  endtask

  // monitor: compares verdicts against the queue
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (exp_hit_q.size() == 0) begin
        check(1'b0, "R8 unexpected res_valid", 32'(res_valid), 32'd0);
      end else begin
        bit    eh;
        int    ei;
        string t;
        eh = exp_hit_q.pop_front();
        ei = exp_idx_q.pop_front();
        t  = tag_q.pop_front();
        check(hit === eh, {t, " hit"}, 32'(hit), 32'(eh));
        check(int'(hit_idx) == ei, {t, " idx"}, 32'(hit_idx), 32'(ei));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      check(1'b0, "watchdog expired", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < NW; w++) begin
      m_en[w] = 0; m_io[w] = 0; m_tpm[w] = 0; m_lo[w] = '0; m_hi[w] = '0;
    end
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;

    // R1: reset state
    check(res_valid === 1'b0, "R1 res_valid after reset", 32'(res_valid), 32'd0);
    for (int s = 0; s < 12; s++) rd(s, 32'h0, "R1 register reset value");
    look(28'h0, 2'd0, "R1 lookup at reset");

    // R2: layout and reserved bits (enable + io, bit28 set, upper tail bits set)
    wr(0, 32'hD000_0100);
    wr(1, 32'hF000_01FF);
    rd(0, 32'hC000_0100, "R2 head readback");
    rd(1, 32'h0000_01FF, "R2 tail readback");

    // R6 inclusive bounds, R4 permissions, R5 fw/reserved kinds
    look(28'h100, 2'd0, "R6 lower bound");
    look(28'h1FF, 2'd0, "R6 upper bound");
    look(28'h0FF, 2'd0, "R6 below lower");
    look(28'h200, 2'd0, "R6 above upper");
    look(28'h150, 2'd1, "R4 tpm not permitted");
    look(28'h150, 2'd2, "R5 firmware kind");
    look(28'h150, 2'd3, "R5 reserved kind");

    // R7: overlapping windows
    wr(2, 32'hA000_0180); wr(3, 32'h0000_0300);   // win1 tpm only
    wr(4, 32'hE000_0150); wr(5, 32'h0000_0400);   // win2 io+tpm
    look(28'h160, 2'd0, "R7 io overlap 0/2");
    look(28'h190, 2'd1, "R7 tpm overlap 1/2");
    look(28'h250, 2'd0, "R4 io skips tpm-only win1");
    look(28'h190, 2'd0, "R7 io overlap 0/2 again");

    // R3: disabled window with wide bounds
    wr(6, 32'h6000_0000); wr(7, 32'h0FFF_FFFF);
    look(28'h500, 2'd0, "R3 disabled window");

    // R6: inverted bounds
    wr(8, 32'hC000_0900); wr(9, 32'h0000_0800);
    look(28'h850, 2'd0, "R6 inverted bounds");

    // top of the address space
    wr(10, 32'hCFFF_FFFF); wr(11, 32'h0FFF_FFFF);
    look(28'hFFF_FFFF, 2'd0, "R6 max address");

    // R10: unused select values
    wr(12, 32'hFFFF_FFFF);
    wr(15, 32'hFFFF_FFFF);
    rd(12, 32'h0, "R10 unused sel 12 read");
    rd(15, 32'h0, "R10 unused sel 15 read");
    rd(0, 32'hC000_0100, "R10 win0 head unchanged");
    rd(11, 32'h0FFF_FFFF, "R10 win5 tail unchanged");
    look(28'h0FF, 2'd0, "R10 lookup unchanged");

    // R9: write and lookup in one cycle
    cycle_op(1'b1, 6, 32'hE000_0000, 1'b1, 28'h500, 2'd0, "R9 enable same cycle");
    look(28'h500, 2'd0, "R9 after enable");
    cycle_op(1'b1, 4, 32'h6000_0150, 1'b1, 28'h250, 2'd0, "R9 disable same cycle");
    look(28'h250, 2'd0, "R9 after disable");

    // R8: back-to-back mixed lookups
    look(28'h100, 2'd0, "R8 burst a");
    look(28'h190, 2'd1, "R8 burst b");
    look(28'h190, 2'd2, "R8 burst c");

    repeat (3) @(posedge clk);
    #1;
    check(exp_hit_q.size() == 0, "R8 all verdicts delivered",
          32'(exp_hit_q.size()), 32'd0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule